// File: doc/BRIEF.md
# Sprite Page DMA Controller

This block copies one page of memory, 256 bytes, into the sprite attribute write port. It sits beside a small 8-bit CPU on a shared address and data bus. A CPU write to the trigger address (0x4014) starts it, and the data byte of that write selects the source page. The block then stalls the CPU through its ready line, takes the bus, and moves the bytes one at a time. Each byte is read from the page and then written to the attribute data port at 0x2004.

The stall works the way the CPU's ready input works. The CPU obeys a low ready only on read cycles, so write cycles that are already under way finish normally. A read-modify-write instruction can therefore write the trigger address twice in a row. The page then comes from the last trigger write that lands before the CPU halts. One idle stall cycle follows the halt, and after it the read and write beats alternate strictly until all 256 pairs are done. Ready and the bus then return to the CPU.

Top module: `spr_page_dma`

## Requirements
- R1: After synchronous reset, and whenever no copy is running, rdy is 1, bus_grant is 0, dma_wr is 0 and dma_addr is 0.
- R2: A CPU write cycle (cpu_rw = 0) to address 0x4014 drives rdy to 0 combinationally in that same cycle. A CPU read of 0x4014, or a CPU write to any other address, leaves rdy at 1 and starts nothing.
- R3: After the trigger write, and until the CPU's first read cycle, CPU writes still complete. Each write to 0x4014 in that window replaces the latched page, so 0x00 followed by 0xFF gives page 0xFF. Writes to other addresses leave the page unchanged.
- R4: The first CPU read cycle after the trigger is a stall cycle: rdy is 0 and bus_grant is 0.
- R5: From the cycle after the stall, bus_grant is 1 and the beats alternate. A read beat has dma_wr = 0 and dma_addr = {page, index}. A write beat has dma_wr = 1 and dma_addr = 0x2004.
- R6: The index (the low address byte) starts at 0x00 and rises by one after each read/write pair, for exactly 256 pairs.
- R7: On each write beat, dma_dout equals the bus_din value sampled on the preceding read beat.
- R8: In the cycle after the write beat of index 0xFF, rdy is 1 and bus_grant is 0.
- R9: CPU writes to 0x4014 during the read and write beats are ignored: the copy neither restarts nor changes its page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_dout | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = CPU read cycle, 0 = CPU write cycle |
| bus_din | input | 8 | Memory read data returned during read beats |
| rdy | output | 1 | Ready to the CPU; 0 stalls it on read cycles |
| bus_grant | output | 1 | 1 while the block owns the bus |
| dma_addr | output | 16 | Address driven during DMA beats |
| dma_wr | output | 1 | 1 on write beats, 0 on read beats |
| dma_dout | output | 8 | Byte driven on write beats |

## Verification
Two events can fall in the same cycle: a CPU write that updates the page while the trigger is still pending, and the CPU halting. The bench provokes the first by issuing two back-to-back trigger writes with different data, and separately a trigger write followed by a write to an unrelated address. It then checks that every read-beat address carries the page of the last trigger write. The bench also drives trigger writes during the beats, which meets the running copy in the same cycle, and checks that the page and the beat cadence do not change.

// File: rtl/spd_pkg.sv
package spd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RD    = 2'd2,
        ST_WR    = 2'd3
    } spd_state_e;

    localparam logic [15:0] DEF_TRIG_ADDR = 16'h4014;
    localparam logic [15:0] DEF_PORT_ADDR = 16'h2004;

    function automatic logic owns_bus(spd_state_e s);
        return (s == ST_RD) || (s == ST_WR);
    endfunction
endpackage

// File: rtl/spd_ctrl.sv
module spd_ctrl
    import spd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(DEF_TRIG_ADDR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_dout,
    input  logic              cpu_rw,
    input  logic              last,
    output spd_state_e        state,
    output logic [PAGE_W-1:0] page,
    output logic              rdy,
    output logic              grant,
    output logic              step
);
    logic trig_wr;

    assign trig_wr = !cpu_rw && (cpu_addr == TRIG_ADDR);
    assign grant   = owns_bus(state);
    assign rdy     = (state == ST_IDLE) && !trig_wr;
    assign step    = (state == ST_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            page  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (trig_wr) begin
                        state <= ST_ARMED;
                        page  <= PAGE_W'(cpu_dout);
                    end
                end
                ST_ARMED: begin
                    if (cpu_rw) begin
                        state <= ST_RD;
                    end else if (trig_wr) begin
                        page <= PAGE_W'(cpu_dout);
                    end
                end
                ST_RD:   state <= ST_WR;
                default: state <= last ? ST_IDLE : ST_RD;
            endcase
        end
    end
endmodule

// File: rtl/spd_index.sv
module spd_index #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    assign last = (idx == {IDX_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/spd_mux.sv
module spd_mux
    import spd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter int PAGE_W = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(DEF_PORT_ADDR)
) (
    input  logic              clk,
    input  logic              rst,
    input  spd_state_e        state,
    input  logic [PAGE_W-1:0] page,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              dma_wr,
    output logic [DATA_W-1:0] dma_dout
);
    logic [DATA_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (state == ST_RD) begin
            hold <= bus_din;
        end
    end

    always_comb begin
        dma_addr = '0;
        dma_wr   = 1'b0;
        dma_dout = '0;
        case (state)
            ST_RD: dma_addr = {page, idx};
            ST_WR: begin
                dma_addr = PORT_ADDR;
                dma_wr   = 1'b1;
                dma_dout = hold;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spr_page_dma.sv
module spr_page_dma
    import spd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(DEF_TRIG_ADDR),
    parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(DEF_PORT_ADDR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_dout,
    input  logic              cpu_rw,
    input  logic [DATA_W-1:0] bus_din,
    output logic              rdy,
    output logic              bus_grant,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              dma_wr,
    output logic [DATA_W-1:0] dma_dout
);
    localparam int PAGE_W = ADDR_W - IDX_W;

    spd_state_e        state;
    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic              step;

    spd_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .TRIG_ADDR(TRIG_ADDR)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_dout(cpu_dout),
        .cpu_rw(cpu_rw), .last(last), .state(state), .page(page),
        .rdy(rdy), .grant(bus_grant), .step(step)
    );

    spd_index #(.IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst(rst), .step(step), .idx(idx), .last(last)
    );

    spd_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W),
        .PORT_ADDR(PORT_ADDR)
    ) u_mux (
        .clk(clk), .rst(rst), .state(state), .page(page), .idx(idx),
        .bus_din(bus_din), .dma_addr(dma_addr), .dma_wr(dma_wr),
        .dma_dout(dma_dout)
    );
endmodule

// File: rtl/spd_chk.sv
module spd_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004
) (
    input logic              clk,
    input logic              rst,
    input logic              rdy,
    input logic              bus_grant,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              dma_wr,
    input logic [DATA_W-1:0] dma_dout,
    input logic [DATA_W-1:0] bus_din
);
    // R4 / R5: the CPU never runs while the bus is taken
    assert_grant_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        bus_grant |-> !rdy);

    // R5: a read beat is always followed by a write beat to the port
    assert_read_then_write_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_grant && !dma_wr) |=> (bus_grant && dma_wr && dma_addr == PORT_ADDR));

    // R7: write data is the byte captured on the read beat
    assert_data_forward_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_grant && !dma_wr) |=> (dma_dout == $past(bus_din)));

    // R6: the next read beat uses the following index
    assert_index_step_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_grant && !dma_wr && dma_addr[7:0] != 8'hFF) |=> ##1
        (bus_grant && !dma_wr && dma_addr[7:0] == 8'($past(dma_addr[7:0], 2) + 1'b1)));

    // R8: the last pair hands the bus back
    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_grant && dma_wr && $past(bus_grant) && $past(dma_addr[7:0]) == 8'hFF)
        |=> (!bus_grant));
endmodule

bind spr_page_dma spd_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
) u_chk (.*);

// File: tb/test_spr_page_dma.sv
module test_spr_page_dma;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_dout;
    logic        cpu_rw;
    logic [7:0]  bus_din;
    logic        rdy;
    logic        bus_grant;
    logic [15:0] dma_addr;
    logic        dma_wr;
    logic [7:0]  dma_dout;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(logic [15:0] a);
        return 8'((a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5);
    endfunction

    assign bus_din = memf(dma_addr);

    spr_page_dma i_spr_page_dma (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_dout(cpu_dout),
        .cpu_rw(cpu_rw), .bus_din(bus_din), .rdy(rdy), .bus_grant(bus_grant),
        .dma_addr(dma_addr), .dma_wr(dma_wr), .dma_dout(dma_dout)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // set CPU inputs shortly after the edge, sample at the falling edge
    task automatic drive(logic [15:0] a, logic [7:0] d, logic rw);
        @(posedge clk);
        #2;
        cpu_addr = a;
        cpu_dout = d;
        cpu_rw   = rw;
        @(negedge clk);
    endtask

    task automatic expect_idle(string req);
        check({req, " rdy"}, 32'(rdy), 1);
        check({req, " grant"}, 32'(bus_grant), 0);
        check({req, " wr"}, 32'(dma_wr), 0);
        check({req, " addr"}, 32'(dma_addr), 0);
    endtask

    // cycles with grant: 256 pairs, then the release cycle
    task automatic run_copy(logic [7:0] page, bit noise);
        for (int i = 0; i < 256; i++) begin
            if (noise) drive(16'h4014, 8'h11, 1'b0);
            else       drive(16'h8000, 8'h00, 1'b1);
            check("R5 read grant", 32'(bus_grant), 1);
            check("R5 read wr", 32'(dma_wr), 0);
            check(noise ? "R9 read addr" : "R6 read addr", 32'(dma_addr), 32'({page, 8'(i)}));
            check("R4 rdy low", 32'(rdy), 0);
            if (noise) drive(16'h4014, 8'h22, 1'b0);
            else       drive(16'h8000, 8'h00, 1'b1);
            check("R5 write wr", 32'(dma_wr), 1);
            check("R5 write addr", 32'(dma_addr), 32'h2004);
            check("R7 write data", 32'(dma_dout), 32'(memf({page, 8'(i)})));
        end
        drive(16'h8000, 8'h00, 1'b1);
        check("R8 rdy released", 32'(rdy), 1);
        check("R8 grant released", 32'(bus_grant), 0);
    endtask

    task automatic stall_cycle();
        drive(16'h8001, 8'h00, 1'b1);
        check("R4 stall rdy", 32'(rdy), 0);
        check("R4 stall grant", 32'(bus_grant), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cpu_addr = 16'h0000; cpu_dout = 8'h00; cpu_rw = 1'b1;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        expect_idle("R1 reset");
    endtask

    task automatic t_no_trigger();
        drive(16'h4014, 8'h33, 1'b1);
        check("R2 read of trigger", 32'(rdy), 1);
        drive(16'h4015, 8'h33, 1'b0);
        check("R2 other write", 32'(rdy), 1);
        drive(16'h8000, 8'h00, 1'b1);
        expect_idle("R2 nothing started");
    endtask

    task automatic t_single();
        drive(16'h4014, 8'h03, 1'b0);
        check("R2 same-cycle rdy", 32'(rdy), 0);
        check("R2 no grant yet", 32'(bus_grant), 0);
        stall_cycle();
        run_copy(8'h03, 1'b0);
        expect_idle("R1 after copy");
    endtask

    task automatic t_double();
        drive(16'h4014, 8'h00, 1'b0);
        check("R3 first trigger rdy", 32'(rdy), 0);
        drive(16'h4014, 8'hFF, 1'b0);
        check("R3 second write no grant", 32'(bus_grant), 0);
        stall_cycle();
        run_copy(8'hFF, 1'b0);
    endtask

    task automatic t_other_write();
        drive(16'h4014, 8'h42, 1'b0);
        drive(16'h0300, 8'h99, 1'b0);
        check("R3 other write no grant", 32'(bus_grant), 0);
        stall_cycle();
        run_copy(8'h42, 1'b0);
    endtask

    task automatic t_noise();
        drive(16'h4014, 8'h5C, 1'b0);
        stall_cycle();
        run_copy(8'h5C, 1'b1);
        drive(16'h8000, 8'h00, 1'b1);
        expect_idle("R9 no restart");
    endtask

    task automatic t_reset_mid();
        drive(16'h4014, 8'h07, 1'b0);
        stall_cycle();
        drive(16'h8000, 8'h00, 1'b1);
        drive(16'h8000, 8'h00, 1'b1);
        check("R5 mid grant", 32'(bus_grant), 1);
        @(posedge clk);
        #2 rst = 1'b1;
        @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        expect_idle("R1 reset mid copy");
    endtask

    initial begin
        t_reset();
        t_no_trigger();
        t_single();
        t_double();
        t_other_write();
        t_noise();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule